// File: doc/BRIEF.md
# Dual-Width Flash Access Bridge

This block sits between a 32-bit memory-mapped host bus and an external parallel flash device accessed over an 8-bit data lane. The host talks to two fixed address regions. One is the flash window. The other holds a one-bit width control register. With the register clear, each host access moves a single flash byte, and only the low byte of the returned word means anything. With the register set, a host read gathers four consecutive flash bytes and returns a full 32-bit word. Writes to the flash are blocked in this wide mode.

Every flash byte cycle holds chip enable together with output enable (read) or write enable (write) low for a fixed, parameterised number of clocks. The read data is captured on the last clock of that window. Between the bytes of a wide read, one clock passes with all strobes inactive. The host issues a one-cycle read or write request while the bridge is idle. It then waits for a one-cycle ready pulse, on which the read data is valid.

Top module: `flash_width_bridge`

## Requirements
- R1: After reset, `host_ready` is 0; `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1; and the width register is 0, which selects byte mode.
- R2: The control register is decoded where `host_addr[31:24]` equals `CTRL_SEL`. A write stores `host_wdata[0]` (1 = word mode, 0 = byte mode). A read returns `{31'b0, mode}`. Both raise `host_ready` in the cycle right after the request edge, with no flash strobe.
- R3: In byte mode, a read in the flash window, where `host_addr[31:24]` equals `FLASH_SEL`, drives `fl_addr = host_addr[FLASH_AW-1:0]`. It returns `{24'b0, byte}` and raises `host_ready` PULSE cycles after the request edge.
- R4: In word mode, a flash read fetches bytes k = 0..3 from `fl_addr = {host_addr[FLASH_AW-3:0], k[1:0]}`. Byte k goes into `host_rdata[8k+7:8k]`, and `host_ready` rises 4*PULSE+3 cycles after the request edge.
- R5: Each flash byte read holds `fl_ce_n` and `fl_oe_n` low for exactly PULSE consecutive cycles. The two strobes `fl_oe_n` and `fl_we_n` are never low together, and neither is low while `fl_ce_n` is high.
- R6: In byte mode, a flash write holds `fl_ce_n` and `fl_we_n` low for PULSE cycles, with `fl_dq_out = host_wdata[7:0]`, `fl_dq_oe` = 1, `fl_oe_n` = 1 and `fl_addr = host_addr[FLASH_AW-1:0]`. Ready follows after PULSE cycles, and `fl_dq_oe` is 1 only while `fl_we_n` is low.
- R7: In word mode, a flash write is refused. `host_ready` rises in the cycle after the request, and `fl_we_n`, `fl_oe_n` and `fl_ce_n` stay high.
- R8: `host_ready` is a single-cycle pulse, and `fl_ce_n` is high whenever it is set.
- R9: A request outside both regions completes with `host_ready` in the next cycle, `host_rdata` = 0 and no flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | One-cycle read request, taken when idle |
| host_wr | input | 1 | One-cycle write request, taken when idle |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| fl_addr | output | FLASH_AW | Flash byte address |
| fl_dq_in | input | 8 | Data from flash |
| fl_dq_out | output | 8 | Data to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
Suppose the width register or the byte index goes wrong inside the block. The next flash read then shows it at the ports: the latency is off (PULSE against 4*PULSE+3), the number of output-enable cycles is off, or bytes land in the wrong lanes of the returned word. A stale or corrupted mode can also let a write strobe through while word mode is set, and the bench would see that on the very next write attempt. A miscounted strobe window changes the length of the low pulse on `fl_oe_n` or `fl_we_n`, and the bench measures that pulse on every byte cycle.

// File: rtl/flash_width_bridge.sv
module flash_width_bridge #(
  parameter int          FLASH_AW  = 21,
  parameter int          PULSE     = 4,
  parameter logic [7:0]  FLASH_SEL = 8'hF8,
  parameter logic [7:0]  CTRL_SEL  = 8'hFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         host_addr,
  input  logic [31:0]         host_wdata,
  input  logic                host_rd,
  input  logic                host_wr,
  output logic [31:0]         host_rdata,
  output logic                host_ready,
  output logic [FLASH_AW-1:0] fl_addr,
  input  logic [7:0]          fl_dq_in,
  output logic [7:0]          fl_dq_out,
  output logic                fl_dq_oe,
  output logic                fl_ce_n,
  output logic                fl_oe_n,
  output logic                fl_we_n
);
  localparam int CW = $clog2(PULSE + 1);

  typedef enum logic [1:0] {IDLE, STROBE, GAP, DONE} state_t;

  state_t              st;
  logic                mode_q, wr_q, wide_q;
  logic [CW-1:0]       cnt;
  logic [1:0]          idx;
  logic [FLASH_AW-1:0] base_q;
  logic [31:0]         data_q;
  logic [7:0]          wd_q;

  wire sel_fl = host_addr[31:24] == FLASH_SEL;
  wire sel_ct = host_addr[31:24] == CTRL_SEL;
  wire last_t = cnt == CW'(PULSE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      mode_q <= 1'b0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      base_q <= '0;
      data_q <= '0;
      wd_q   <= '0;
    end else begin
      case (st)
        IDLE: if (host_rd || host_wr) begin
          wr_q   <= host_wr;
          wide_q <= mode_q;
          idx    <= '0;
          cnt    <= '0;
          wd_q   <= host_wdata[7:0];
          data_q <= '0;
          base_q <= mode_q ? {host_addr[FLASH_AW-3:0], 2'b00} : host_addr[FLASH_AW-1:0];
          if (sel_fl && !(host_wr && mode_q)) st <= STROBE;
          else begin
            st <= DONE;
            if (sel_ct) begin
              if (host_wr) mode_q <= host_wdata[0];
              else         data_q <= {31'b0, mode_q};
            end
          end
        end
        STROBE: if (last_t) begin
          if (!wr_q) data_q[{idx, 3'b000} +: 8] <= fl_dq_in;
          cnt <= '0;
          if (!wide_q || wr_q || idx == 2'd3) st <= DONE;
          else begin
            idx <= idx + 2'd1;
            st  <= GAP;
          end
        end else cnt <= cnt + 1'b1;
        GAP:     st <= STROBE;
        default: st <= IDLE;
      endcase
    end
  end

  assign fl_addr    = base_q | FLASH_AW'(idx);
  assign fl_ce_n    = st != STROBE;
  assign fl_oe_n    = !(st == STROBE && !wr_q);
  assign fl_we_n    = !(st == STROBE && wr_q);
  assign fl_dq_oe   = st == STROBE && wr_q;
  assign fl_dq_out  = wd_q;
  assign host_ready = st == DONE;
  assign host_rdata = data_q;
endmodule

module flash_width_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic host_ready,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n,
  input logic fl_dq_oe,
  input logic mode_q
);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  // R8
  ready_idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> fl_ce_n);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));
  // R5
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n || !fl_we_n) |-> !fl_ce_n);
  // R7
  word_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> fl_we_n);
  // R6
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> !fl_we_n);
endmodule

bind flash_width_bridge flash_width_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .fl_ce_n(fl_ce_n),
  .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_dq_oe(fl_dq_oe), .mode_q(mode_q)
);

// File: tb/flash_width_bridge_tb.sv
module flash_width_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FAW = 21;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic [31:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic host_rd = 0, host_wr = 0, host_ready;
  logic [FAW-1:0] fl_addr;
  logic [7:0] fl_dq_in, fl_dq_out;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0, failures = 0;
  int oe_cyc = 0, we_cyc = 0, run = 0, runs_bad = 0, wrun = 0;
  logic [FAW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic drv_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fb(input logic [FAW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] ha);
    logic [FAW-1:0] b;
    b = {ha[FAW-3:0], 2'b00};
    return {fb(b | 3), fb(b | 2), fb(b | 1), fb(b)};
  endfunction

  assign fl_dq_in = fb(fl_addr);

  flash_width_bridge #(.FLASH_AW(FAW), .PULSE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .host_ready(host_ready), .fl_addr(fl_addr), .fl_dq_in(fl_dq_in),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  always @(negedge clk) begin
    if (!fl_oe_n) begin oe_cyc++; run++; end
    else if (run != 0) begin if (run != P) runs_bad++; run = 0; end
    if (!fl_we_n) begin
      we_cyc++; wrun++; wr_addr = fl_addr; wr_data = fl_dq_out;
      if (!fl_dq_oe || !fl_oe_n) drv_bad = 1;
    end else if (wrun != 0) begin if (wrun != P) runs_bad++; wrun = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    oe_cyc = 0; we_cyc = 0; runs_bad = 0; drv_bad = 0;
    host_addr = addr; host_wdata = wd; host_rd = !wr; host_wr = wr;
    @(posedge clk); #1;
    host_rd = 0; host_wr = 0;
    lat = 0;
    while (!host_ready && lat < 1000) begin @(posedge clk); #1; lat++; end
    rd = host_rdata;
    @(posedge clk); #1;
    chk("R8 ready single pulse", {31'b0, host_ready}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, a;
    int lat;
    logic mode;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", {31'b0, host_ready}, 0);
    chk("R1 strobes idle", {29'b0, fl_ce_n, fl_oe_n, fl_we_n}, 32'd7);
    rst_n = 1;

    access(0, 32'hFC000000, 0, rd, lat);
    chk("R1 mode after reset", rd, 0);
    chk("R2 ctrl latency", lat, 0);

    access(0, 32'hF8001234, 0, rd, lat);
    chk("R3 byte read data", rd, {24'b0, fb(21'h1234)});
    chk("R3 byte read latency", lat, P);
    chk("R5 oe cycles byte", oe_cyc, P);
    chk("R5 pulse widths", runs_bad, 0);

    access(1, 32'hF8000077, 32'hABCDEF3C, rd, lat);
    chk("R6 we cycles", we_cyc, P);
    chk("R6 write addr", {11'b0, wr_addr}, 32'h77);
    chk("R6 write data", {24'b0, wr_data}, 32'h3C);
    chk("R6 write latency", lat, P);
    chk("R6 no oe on write", oe_cyc, 0);
    chk("R6 drive tied to we", {31'b0, drv_bad}, 0);

    access(1, 32'hFC000000, 32'h00000001, rd, lat);
    chk("R2 ctrl write latency", lat, 0);
    access(0, 32'hFC000000, 0, rd, lat);
    chk("R2 ctrl readback", rd, 1);

    access(0, 32'hF8000105, 0, rd, lat);
    chk("R4 word data", rd, exp_word(32'hF8000105));
    chk("R4 word latency", lat, 4*P+3);
    chk("R5 oe cycles word", oe_cyc, 4*P);
    chk("R5 pulse widths word", runs_bad, 0);

    access(0, 32'hF807FFFF, 0, rd, lat);
    chk("R4 word top index", rd, exp_word(32'hF807FFFF));

    access(1, 32'hF8000010, 32'h55, rd, lat);
    chk("R7 refused latency", lat, 0);
    chk("R7 no we", we_cyc, 0);
    chk("R7 no oe", oe_cyc, 0);

    access(0, 32'h12345678, 0, rd, lat);
    chk("R9 unmapped data", rd, 0);
    chk("R9 unmapped latency", lat, 0);
    chk("R9 unmapped no strobe", oe_cyc + we_cyc, 0);

    mode = 1;
    for (int i = 0; i < 60; i++) begin
      int kind;
      kind = $urandom % 4;
      a = $urandom;
      case (kind)
        0: begin
          mode = a[0];
          access(1, 32'hFC000000, {31'b0, mode}, rd, lat);
          chk("R2 rand ctrl write latency", lat, 0);
        end
        1: begin
          a[31:24] = 8'hF8;
          access(0, a, 0, rd, lat);
          if (mode) begin
            chk("R4 rand word data", rd, exp_word(a));
            chk("R4 rand word latency", lat, 4*P+3);
          end else begin
            chk("R3 rand byte data", rd, {24'b0, fb(a[FAW-1:0])});
            chk("R3 rand byte latency", lat, P);
          end
          chk("R5 rand pulse widths", runs_bad, 0);
        end
        2: begin
          a[31:24] = 8'hF8;
          access(1, a, {$urandom}, rd, lat);
          chk("R6 R7 rand we cycles", we_cyc, mode ? 0 : P);
          if (!mode) chk("R6 rand write data", {24'b0, wr_data}, {24'b0, host_wdata[7:0]});
        end
        default: begin
          access(0, 32'hFC000000, 0, rd, lat);
          chk("R2 rand ctrl read", rd, {31'b0, mode});
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule